// File: doc/BRIEF.md
# I2C Serial-Data Output Delay Unit

This block sits between the bit shifter of an I2C interface and the open-drain driver of the data line. It takes the undelayed data drive value and holds it back by a programmable number of baud-prescaler ticks. Every data transition then lands well inside the clock-low phase, and a data edge cannot appear while the clock is high. A data edge during clock-high would be read on the bus as a start or stop condition.

A 3-bit setting chooses the delay. Zero makes the block a transparent wire in the same cycle. A nonzero value N makes an input change show at the output on the (N+1)th prescaler tick after the change. The change itself is not aligned to the tick grid, so the delay seen on the bus lies between N and N+1 tick periods. A change that arrives while another is still waiting replaces it and restarts the count. The setting is only taken in while nothing is waiting, so a pending change always completes under the setting it started with.

Top module: `sda_delay_unit`

## Requirements
- R1: Reset clears any waiting change and sets the held output value to 1. Once reset is released with `sdaIn` at 1 and a nonzero setting, `sdaOut` reads 1 and stays at 1 across later ticks.
- R2: While the active setting is 0, `sdaOut` equals `sdaIn` in the same cycle, and no tick is needed.
- R3: With an active setting N from 1 to 7, `sdaOut` keeps its previous value through the first N ticks after an input change. It takes the new value at the clock edge that samples the (N+1)th tick. Idle cycles between ticks do not matter.
- R4: A tick in the same cycle as the clock edge that first sees an input change is not counted. Counting starts with the ticks in later cycles.
- R5: An input change that arrives while an earlier change is waiting replaces the waiting value and restarts the count from zero.
- R6: If the input returns to the current output value before a waiting change has been applied, `sdaOut` does not change at all.
- R7: A new value on `delaySel` is ignored while a change is waiting: that change completes with the old setting. The new value applies to the next change.
- R8: A change that is waiting when reset is asserted is discarded and never reaches the output.
- R9: Without ticks, a waiting change is held indefinitely and `sdaOut` does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle strobe from the baud prescaler |
| sdaIn | input | 1 | Undelayed data drive value from the shifter (1 = released) |
| delaySel | input | 3 | Delay setting in ticks; 0 selects bypass |
| sdaOut | output | 1 | Delayed data drive value for the open-drain enable |

## Verification
A sweep covers every nonzero setting. Each setting is tried with tick periods of 1, 2 and 4 clocks and with both edge directions. The sweep checks the output after every tick and after the idle gaps, which separates an off-by-one in the tick count from a count that runs on system clocks. Extra sequences cover a tick in the change cycle, a second change and a reversal during a wait, a setting change during a wait, a long stretch without ticks, and a reset in the middle of a wait. These show that restart, replacement, setting capture and discard each behave as required. Bypass is checked on both edges within the same cycle as the input change.

// File: rtl/sda_dly_pkg.sv
package sda_dly_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic track;     // bypass: held value follows input
    logic loadSel;   // capture new delay setting
    logic loadPend;  // capture changed input, restart count
    logic incCnt;    // one tick counted
    logic apply;     // move waiting value to output
  } dlyStrobeT;
endpackage

// File: rtl/sda_dly_ctrl.sv
module sda_dly_ctrl
  import sda_dly_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] cnt,
  input  logic [SEL_W-1:0] activeSel,
  output dlyStrobeT        stb,
  output logic             pending,
  output logic             bypass
);
  logic lastIn;
  logic inChange;
  logic tickLive;
  logic atLimit;

  always_ff @(posedge clk) begin
    if (!rstN) lastIn <= 1'b1;
    else       lastIn <= sdaIn;
  end

  assign inChange = sdaIn != lastIn;
  assign bypass   = activeSel == '0;
  assign tickLive = !bypass && !inChange && pending && tickEn;
  assign atLimit  = cnt == activeSel;

  always_comb begin
    stb          = '0;
    stb.track    = bypass;
    stb.loadSel  = !pending;
    stb.loadPend = !bypass && inChange;
    stb.incCnt   = tickLive && !atLimit;
    stb.apply    = tickLive && atLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pending <= 1'b0;
    else if (bypass)       pending <= 1'b0;
    else if (stb.loadPend) pending <= 1'b1;
    else if (stb.apply)    pending <= 1'b0;
  end

  // R3: count never passes the active setting while waiting
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (cnt <= activeSel));

  // R5: any seen change restarts the count
  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && inChange) |=> (cnt == '0));

  // R2: bypass leaves nothing waiting
  p_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    bypass |=> !pending);
endmodule

// File: rtl/sda_dly_path.sv
module sda_dly_path
  import sda_dly_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] delaySel,
  input  dlyStrobeT        stb,
  input  logic             bypass,
  output logic [SEL_W-1:0] cnt,
  output logic [SEL_W-1:0] activeSel,
  output logic             sdaOut
);
  logic outReg;
  logic pendVal;

  always_ff @(posedge clk) begin
    if (!rstN)           activeSel <= '0;
    else if (stb.loadSel) activeSel <= delaySel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pendVal <= 1'b1;
    else if (stb.loadPend) pendVal <= sdaIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (stb.loadPend) cnt <= '0;
    else if (stb.incCnt)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outReg <= 1'b1;
    else if (stb.track) outReg <= sdaIn;
    else if (stb.apply) outReg <= pendVal;
  end

  assign sdaOut = bypass ? sdaIn : outReg;

  // R1: reset leaves the held value released
  p_reset_release_r1: assert property (@(posedge clk)
    !rstN |=> outReg);

  // R9: held value moves only on an apply or bypass tracking
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.apply && !stb.track) |=> $stable(outReg));
endmodule

// File: rtl/sda_delay_unit.sv
module sda_delay_unit
  import sda_dly_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] delaySel,
  output logic             sdaOut
);
  dlyStrobeT        stb;
  logic             pending;
  logic             bypass;
  logic [SEL_W-1:0] cnt;
  logic [SEL_W-1:0] activeSel;

  sda_dly_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sdaIn(sdaIn),
    .cnt(cnt), .activeSel(activeSel),
    .stb(stb), .pending(pending), .bypass(bypass)
  );

  sda_dly_path #(.SEL_W(SEL_W)) uPath (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .delaySel(delaySel),
    .stb(stb), .bypass(bypass),
    .cnt(cnt), .activeSel(activeSel), .sdaOut(sdaOut)
  );

  // R7: setting frozen while a change waits
  p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> $stable(activeSel));
endmodule

// File: tb/sda_delay_unit_test.sv
module sda_delay_unit_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       sdaIn;
  logic [2:0] delaySel;
  logic       sdaOut;
  int         checks = 0;
  int         errors = 0;
  logic       expOut;
  bit         done = 0;

  always #2.5 clk = ~clk;

  sda_delay_unit uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sdaIn(sdaIn),
    .delaySel(delaySel), .sdaOut(sdaOut)
  );

  task automatic chk(string req, logic exp);
    checks++;
    if (sdaOut !== exp) begin
      errors++;
      $display("FAIL %s: sdaOut=%0b expected %0b at %0t", req, sdaOut, exp, $time);
    end
  endtask

  task automatic tickPulse();
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Full delay trial: change then N+1 ticks spaced by per clocks
  task automatic delayTrial(int sel, int per);
    logic oldV;
    logic newV;
    oldV = expOut;
    newV = !expOut;
    delaySel = 3'(sel);
    idle(3);
    chk("R3", oldV);
    sdaIn = newV;
    @(negedge clk);
    chk("R3", oldV);
    for (int k = 1; k <= sel + 1; k++) begin
      tickPulse();
      chk("R3", (k <= sel) ? oldV : newV);
      if (per > 1) begin
        idle(per - 1);
        chk("R3", (k <= sel) ? oldV : newV);
      end
    end
    expOut = newV;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; sdaIn = 1'b1; delaySel = 3'd0;
    expOut = 1'b1;
    idle(3);
    chk("R1", 1'b1);
    rstN = 1'b1;
    idle(2);

    // R2: bypass, both edges, same cycle
    sdaIn = 1'b0; #1 chk("R2", 1'b0);
    @(negedge clk); sdaIn = 1'b1; #1 chk("R2", 1'b1);
    @(negedge clk);

    // R3: sweep every setting, several tick spacings, both directions
    for (int p = 1; p <= 4; p = p * 2)
      for (int s = 1; s <= 7; s++) begin
        delayTrial(s, p);
        delayTrial(s, p);
      end

    // R4: tick in the change cycle is not counted
    delaySel = 3'd1; idle(3);
    sdaIn = !expOut; tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    chk("R4", expOut);
    tickPulse(); chk("R4", expOut);
    tickPulse(); chk("R4", !expOut);
    expOut = !expOut;

    // R5: second change restarts the count
    delaySel = 3'd3; idle(3);
    sdaIn = !expOut; @(negedge clk);
    tickPulse(); tickPulse(); chk("R5", expOut);
    sdaIn = expOut; @(negedge clk);
    tickPulse(); chk("R5", expOut);
    sdaIn = !expOut; @(negedge clk);
    for (int k = 1; k <= 3; k++) begin tickPulse(); chk("R5", expOut); end
    tickPulse(); chk("R5", !expOut);
    expOut = !expOut;

    // R6: reversal before apply leaves output untouched
    sdaIn = !expOut; @(negedge clk);
    tickPulse(); tickPulse();
    sdaIn = expOut; @(negedge clk);
    for (int k = 1; k <= 6; k++) begin tickPulse(); chk("R6", expOut); end

    // R7: setting change while waiting is deferred
    delaySel = 3'd7; idle(3);
    sdaIn = !expOut; @(negedge clk);
    delaySel = 3'd1;
    for (int k = 1; k <= 7; k++) begin tickPulse(); chk("R7", expOut); end
    tickPulse(); chk("R7", !expOut);
    expOut = !expOut;
    idle(2);
    sdaIn = !expOut; @(negedge clk);
    tickPulse(); chk("R7", expOut);
    tickPulse(); chk("R7", !expOut);
    expOut = !expOut;

    // R9: no ticks, nothing moves
    delaySel = 3'd2; idle(3);
    sdaIn = !expOut; @(negedge clk);
    idle(50); chk("R9", expOut);
    for (int k = 1; k <= 2; k++) begin tickPulse(); chk("R9", expOut); end
    tickPulse(); chk("R9", !expOut);
    expOut = !expOut;

    // bring output to 0 for the reset tests
    if (expOut) delayTrial(2, 1);

    // R1: reset with output at 0 returns it to 1, no later spurious change
    rstN = 1'b0; sdaIn = 1'b1; idle(2);
    rstN = 1'b1; idle(3);
    chk("R1", 1'b1);
    for (int k = 1; k <= 4; k++) begin tickPulse(); chk("R1", 1'b1); end
    expOut = 1'b1;

    // R8: waiting change discarded by reset
    sdaIn = 1'b0; @(negedge clk);
    tickPulse(); chk("R8", 1'b1);
    rstN = 1'b0; sdaIn = 1'b1; idle(2);
    rstN = 1'b1; idle(3);
    for (int k = 1; k <= 5; k++) begin tickPulse(); chk("R8", 1'b1); end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule